// File: doc/BRIEF.md
# Burst DMA request generator

This block raises the DMA request lines for a serial bus master that moves a programmed number of bytes in burst mode. It has a transmit FIFO and a receive FIFO. It watches four things: the fill level of each FIFO, a programmable trigger level, the burst length written for the transfer, and its own count of bytes still to be moved. From these it drives a single request and a burst request for each direction. The bus protocol engine, the FIFO storage and the DMA engine sit outside the block. They appear only as level inputs, strobe inputs and request outputs.

The count is loaded when a burst command is issued. It goes down by one for every byte pushed into the transmit FIFO and for every byte popped from the receive FIFO. Once the count reaches zero, the block stays silent until the next command.

The DMA engine reports each completed transfer with a done pulse for its direction. The block latches each pulse into an interrupt flag. Each flag has a mask, a masked view, a combined interrupt line and a write-one-to-clear strobe.

No data stream crosses this block, so there is no valid/ready pair at its edge. The request outputs are level signals. The DMA engine shows that it has taken data through the push and pop strobes. A request therefore stays high until the FIFO level or the remaining count that produced it changes, and nothing needs to be held back at the block's edge.

Top module: `burst_dma_req`

## Requirements
- R1: While `rst_n` is low, all four request outputs, `int_raw`, `int_mis` and `irq` are 0, and the remaining count is 0.
- R2: A request output can be 1 only if `burst_en` and `chan_sel` were both 1 at the clock edge that registered it. Otherwise all four requests are 0.
- R3: `rx_sreq` is 1 when the receive FIFO held at least one byte and the remaining count is nonzero.
- R4: `rx_breq` is 1 when all three hold: the receive level was above `trig_lvl`, the receive level was at least 4, and the remaining count is nonzero. `rx_breq` implies `rx_sreq`.
- R5: `tx_sreq` is 1 when the transmit FIFO had at least one free entry (level below the depth of 8) and the remaining count is nonzero.
- R6: `tx_breq` is 1 only when the remaining count is at least 4 and the transmit level was below `trig_lvl`. With fewer than 4 bytes remaining, only `tx_sreq` may assert. `tx_breq` implies `tx_sreq`.
- R7: A burst command loads the remaining count from `burst_len`, including while a burst is in progress. A command in the same cycle as a byte strobe takes precedence over that strobe. Otherwise each of `tx_push` and `rx_pop` subtracts one, and the count saturates at 0.
- R8: When the remaining count is 0, which includes a burst length of 0, no request of either kind is produced until the next burst command.
- R9: Requests are registered. The values after a clock edge are computed from the enables and levels sampled at that edge and from the remaining count as updated at that same edge. A request therefore falls in the cycle after the last byte is counted, and rises in the cycle after the command.
- R10: A pulse on `done_tx` sets `int_raw[0]` and a pulse on `done_rx` sets `int_raw[1]`. Each bit stays set until it is cleared. If a set and a clear arrive in the same cycle, the set wins.
- R11: `int_mis` equals `int_raw` AND `int_mask`, and `irq` is the OR of the `int_mis` bits. A 1 on `int_clr[i]` clears `int_raw[i]` at the next edge, and a 0 on `int_clr[i]` leaves that bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_en | input | 1 | Burst mode enabled |
| chan_sel | input | 1 | DMA channel for this master is selected |
| burst_cmd | input | 1 | One-cycle burst command; loads the remaining count |
| burst_len | input | LEN_W (8) | Number of bytes in the burst |
| trig_lvl | input | TRIG_W (3) | FIFO trigger level |
| tx_level | input | LVL_W (4) | Transmit FIFO fill level, 0 to 8 |
| rx_level | input | LVL_W (4) | Receive FIFO fill level, 0 to 8 |
| tx_push | input | 1 | A byte was written into the transmit FIFO |
| rx_pop | input | 1 | A byte was taken from the receive FIFO |
| done_tx | input | 1 | Transmit done pulse from the DMA engine |
| done_rx | input | 1 | Receive done pulse from the DMA engine |
| int_mask | input | 2 | Interrupt mask; bit 0 is transmit, bit 1 is receive |
| int_clr | input | 2 | Write-one-to-clear strobes for the interrupt flags |
| tx_sreq | output | 1 | Transmit single request |
| tx_breq | output | 1 | Transmit burst request |
| rx_sreq | output | 1 | Receive single request |
| rx_breq | output | 1 | Receive burst request |
| int_raw | output | 2 | Raw interrupt status |
| int_mis | output | 2 | Masked interrupt status |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its defaults: FIFO depth 8, an 8-bit burst length and a 3-bit trigger. With these settings a completely full FIFO (level 8) can be driven. Every trigger value from 0 to 7 can be applied against every fill level. Short burst lengths of 0 to 5 straddle the four-byte threshold for burst requests. Directed phases cover the following cases:
- a restart in the middle of a burst;
- a zero-length burst;
- gating by the enables;
- an interrupt set and clear landing in the same cycle.

A long random phase then compares every output against a behavioural model on every clock.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
  localparam int unsigned MIN_BURST = 4;

  typedef enum logic {
    DIR_TX = 1'b0,
    DIR_RX = 1'b1
  } dir_e;

  typedef struct packed {
    logic single;
    logic burst;
  } req_pair_t;
endpackage

// File: rtl/bdr_remaining.sv
module bdr_remaining #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  input  logic             dec_tx,
  input  logic             dec_rx,
  output logic [LEN_W-1:0] cnt_q,
  output logic [LEN_W-1:0] cnt_nxt
);
  logic [1:0]       amt;
  logic [LEN_W-1:0] amt_ext;

  assign amt     = {1'b0, dec_tx} + {1'b0, dec_rx};
  assign amt_ext = LEN_W'(amt);

  always_comb begin
    cnt_nxt = cnt_q;
    if (load) begin
      cnt_nxt = len;
    end else if (cnt_q >= amt_ext) begin
      cnt_nxt = cnt_q - amt_ext;
    end else begin
      cnt_nxt = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/bdr_req_lane.sv
module bdr_req_lane
  import bdr_pkg::*;
#(
  parameter bit IS_RX  = 1'b0,
  parameter int DEPTH  = 8,
  parameter int LVL_W  = 4,
  parameter int TRIG_W = 3,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [LVL_W-1:0]  level,
  input  logic [TRIG_W-1:0] trig,
  input  logic [LEN_W-1:0]  remain,
  output req_pair_t         req_q
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] MIN_LVL  = LVL_W'(MIN_BURST);
  localparam logic [LEN_W-1:0] MIN_CNT  = LEN_W'(MIN_BURST);

  logic [LVL_W-1:0] trig_ext;
  logic             have_bytes;
  req_pair_t        req_d;

  assign trig_ext   = LVL_W'(trig);
  assign have_bytes = (remain != '0);

  generate
    if (IS_RX) begin : g_rx
      always_comb begin
        req_d.single = enable && have_bytes && (level != '0);
        req_d.burst  = enable && have_bytes && (level > trig_ext) &&
                       (level >= MIN_LVL);
      end
    end else begin : g_tx
      always_comb begin
        req_d.single = enable && have_bytes && (level < FULL_LVL);
        req_d.burst  = enable && (remain >= MIN_CNT) && (level < trig_ext);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_d;
  end
endmodule

// File: rtl/bdr_irq_flags.sv
module bdr_irq_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] mask,
  output logic [N-1:0] raw_q,
  output logic [N-1:0] mis,
  output logic         irq
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      raw_q[i] <= 1'b0;
        else if (set[i]) raw_q[i] <= 1'b1;
        else if (clr[i]) raw_q[i] <= 1'b0;
      end
    end
  endgenerate

  assign mis = raw_q & mask;
  assign irq = |mis;
endmodule

// File: rtl/burst_dma_req.sv
module burst_dma_req
  import bdr_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int LEN_W  = 8,
  parameter int TRIG_W = 3,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              burst_en,
  input  logic              chan_sel,
  input  logic              burst_cmd,
  input  logic [LEN_W-1:0]  burst_len,
  input  logic [TRIG_W-1:0] trig_lvl,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              tx_push,
  input  logic              rx_pop,
  input  logic              done_tx,
  input  logic              done_rx,
  input  logic [1:0]        int_mask,
  input  logic [1:0]        int_clr,
  output logic              tx_sreq,
  output logic              tx_breq,
  output logic              rx_sreq,
  output logic              rx_breq,
  output logic [1:0]        int_raw,
  output logic [1:0]        int_mis,
  output logic              irq
);
  logic [LEN_W-1:0] remain_q;
  logic [LEN_W-1:0] remain_d;
  logic             req_enable;
  logic [LVL_W-1:0] lane_level [2];
  req_pair_t        lane_req   [2];

  assign req_enable = burst_en & chan_sel;
  assign lane_level[DIR_TX] = tx_level;
  assign lane_level[DIR_RX] = rx_level;

  bdr_remaining #(.LEN_W(LEN_W)) u_remain (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (burst_cmd),
    .len     (burst_len),
    .dec_tx  (tx_push),
    .dec_rx  (rx_pop),
    .cnt_q   (remain_q),
    .cnt_nxt (remain_d)
  );

  generate
    for (genvar d = 0; d < 2; d++) begin : g_lane
      bdr_req_lane #(
        .IS_RX  (d == 1),
        .DEPTH  (DEPTH),
        .LVL_W  (LVL_W),
        .TRIG_W (TRIG_W),
        .LEN_W  (LEN_W)
      ) u_lane (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (req_enable),
        .level  (lane_level[d]),
        .trig   (trig_lvl),
        .remain (remain_d),
        .req_q  (lane_req[d])
      );
    end
  endgenerate

  assign tx_sreq = lane_req[DIR_TX].single;
  assign tx_breq = lane_req[DIR_TX].burst;
  assign rx_sreq = lane_req[DIR_RX].single;
  assign rx_breq = lane_req[DIR_RX].burst;

  bdr_irq_flags #(.N(2)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set   ({done_rx, done_tx}),
    .clr   (int_clr),
    .mask  (int_mask),
    .raw_q (int_raw),
    .mis   (int_mis),
    .irq   (irq)
  );
endmodule

// File: rtl/burst_dma_req_chk.sv
module burst_dma_req_chk #(
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             burst_en,
  input logic             chan_sel,
  input logic             burst_cmd,
  input logic [LEN_W-1:0] burst_len,
  input logic             tx_push,
  input logic             rx_pop,
  input logic             done_tx,
  input logic             done_rx,
  input logic [1:0]       int_mask,
  input logic             tx_sreq,
  input logic             tx_breq,
  input logic             rx_sreq,
  input logic             rx_breq,
  input logic [1:0]       int_raw,
  input logic             irq,
  input logic [LEN_W-1:0] remain
);
  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(burst_en && chan_sel) |=> (!tx_sreq && !tx_breq && !rx_sreq && !rx_breq));

  p_rx_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_breq |-> rx_sreq);

  p_tx_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_breq |-> tx_sreq);

  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    burst_cmd |=> (remain == $past(burst_len)));

  p_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_cmd && tx_push && !rx_pop && remain != '0) |=>
      (remain == $past(remain) - LEN_W'(1)));

  p_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (remain == '0 && !burst_cmd) |=> (!tx_sreq && !tx_breq && !rx_sreq && !rx_breq));

  p_set_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_tx |=> int_raw[0]);

  p_set_rx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_rx |=> int_raw[1]);

  p_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (int_mask == 2'b00) |-> !irq);
endmodule

bind burst_dma_req burst_dma_req_chk #(.LEN_W(LEN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .burst_en  (burst_en),
  .chan_sel  (chan_sel),
  .burst_cmd (burst_cmd),
  .burst_len (burst_len),
  .tx_push   (tx_push),
  .rx_pop    (rx_pop),
  .done_tx   (done_tx),
  .done_rx   (done_rx),
  .int_mask  (int_mask),
  .tx_sreq   (tx_sreq),
  .tx_breq   (tx_breq),
  .rx_sreq   (rx_sreq),
  .rx_breq   (rx_breq),
  .int_raw   (int_raw),
  .irq       (irq),
  .remain    (remain_q)
);

// File: tb/tb_burst_dma_req.sv
module tb_burst_dma_req;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 8;
  localparam int LEN_W  = 8;
  localparam int TRIG_W = 3;
  localparam int LVL_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              burst_en = 1'b0, chan_sel = 1'b0, burst_cmd = 1'b0;
  logic [LEN_W-1:0]  burst_len = '0;
  logic [TRIG_W-1:0] trig_lvl = '0;
  logic [LVL_W-1:0]  tx_level = '0, rx_level = '0;
  logic              tx_push = 1'b0, rx_pop = 1'b0;
  logic              done_tx = 1'b0, done_rx = 1'b0;
  logic [1:0]        int_mask = '0, int_clr = '0;
  logic              tx_sreq, tx_breq, rx_sreq, rx_breq, irq;
  logic [1:0]        int_raw, int_mis;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // behavioural model state
  int m_cnt = 0;
  bit m_tx_s = 0, m_tx_b = 0, m_rx_s = 0, m_rx_b = 0;
  bit m_raw[2] = '{0, 0};

  always #(CLK_PERIOD / 2) clk = ~clk;

  burst_dma_req #(.DEPTH(DEPTH), .LEN_W(LEN_W), .TRIG_W(TRIG_W)) dut (
    .clk(clk), .rst_n(rst_n), .burst_en(burst_en), .chan_sel(chan_sel),
    .burst_cmd(burst_cmd), .burst_len(burst_len), .trig_lvl(trig_lvl),
    .tx_level(tx_level), .rx_level(rx_level), .tx_push(tx_push), .rx_pop(rx_pop),
    .done_tx(done_tx), .done_rx(done_rx), .int_mask(int_mask), .int_clr(int_clr),
    .tx_sreq(tx_sreq), .tx_breq(tx_breq), .rx_sreq(rx_sreq), .rx_breq(rx_breq),
    .int_raw(int_raw), .int_mis(int_mis), .irq(irq)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: got %0d expected %0d", tag, $time, got, exp);
    end
  endtask

  // reference model: updated at each rising edge from the sampled inputs
  always @(posedge clk) begin
    int amt;
    bit en;
    if (!rst_n) begin
      m_cnt = 0;
      m_tx_s = 0; m_tx_b = 0; m_rx_s = 0; m_rx_b = 0;
      m_raw[0] = 0; m_raw[1] = 0;
    end else begin
      amt = int'(tx_push) + int'(rx_pop);
      if (burst_cmd) m_cnt = int'(burst_len);
      else if (m_cnt >= amt) m_cnt = m_cnt - amt;
      else m_cnt = 0;
      en = burst_en && chan_sel;
      m_rx_s = en && m_cnt > 0 && int'(rx_level) >= 1;
      m_rx_b = en && m_cnt > 0 && int'(rx_level) > int'(trig_lvl) && int'(rx_level) >= 4;
      m_tx_s = en && m_cnt > 0 && int'(tx_level) < DEPTH;
      m_tx_b = en && m_cnt >= 4 && int'(tx_level) < int'(trig_lvl);
      if (done_tx) m_raw[0] = 1; else if (int_clr[0]) m_raw[0] = 0;
      if (done_rx) m_raw[1] = 1; else if (int_clr[1]) m_raw[1] = 0;
    end
  end

  // compare on every clock, away from the rising edge
  always @(negedge clk) begin
    bit [1:0] e_raw, e_mis;
    if (!finished) begin
      e_raw = {m_raw[1], m_raw[0]};
      e_mis = e_raw & int_mask;
      check("R5 tx_sreq", int'(tx_sreq), int'(m_tx_s));
      check("R6 tx_breq", int'(tx_breq), int'(m_tx_b));
      check("R3 rx_sreq", int'(rx_sreq), int'(m_rx_s));
      check("R4 rx_breq", int'(rx_breq), int'(m_rx_b));
      check("R10 int_raw", int'(int_raw), int'(e_raw));
      check("R11 int_mis", int'(int_mis), int'(e_mis));
      check("R11 irq", int'(irq), int'(|e_mis));
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic idle_strobes();
    burst_cmd = 0; tx_push = 0; rx_pop = 0; done_tx = 0; done_rx = 0; int_clr = '0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    // R1: reset state
    repeat (3) tick();
    check("R1 reset tx_sreq", int'(tx_sreq), 0);
    check("R1 reset rx_sreq", int'(rx_sreq), 0);
    check("R1 reset irq", int'(irq), 0);
    rst_n = 1;
    tick();

    // transmit burst of 6, trigger 4
    burst_en = 1; chan_sel = 1; trig_lvl = 3'd4; tx_level = 0; burst_len = 8'd6;
    burst_cmd = 1;
    check("R9 no request before command edge", int'(tx_sreq), 0);
    tick();
    burst_cmd = 0;
    check("R9 tx_breq rises after command", int'(tx_breq), 1);
    for (int i = 0; i < 6; i++) begin
      tx_push = 1;
      tick();
      tx_level = tx_level + 1'b1;
    end
    tx_push = 0;
    check("R8 tx_sreq low after last byte", int'(tx_sreq), 0);
    check("R8 tx_breq low after last byte", int'(tx_breq), 0);
    tx_level = 0;
    tick();
    check("R8 stays silent at zero count", int'(tx_sreq), 0);

    // gating by enables
    burst_en = 0; burst_len = 8'd5; burst_cmd = 1;
    tick();
    burst_cmd = 0;
    check("R2 gated tx_sreq", int'(tx_sreq), 0);
    burst_en = 1; chan_sel = 0;
    tick();
    check("R2 gated by channel select", int'(tx_breq), 0);
    chan_sel = 1;
    tick();
    check("R2 released", int'(tx_breq), 1);

    // receive burst of 5, trigger 3
    trig_lvl = 3'd3; tx_level = 4'd8; burst_len = 8'd5; burst_cmd = 1;
    tick();
    burst_cmd = 0;
    check("R3 empty rx fifo no request", int'(rx_sreq), 0);
    rx_level = 4'd3;
    tick();
    check("R3 rx single with data", int'(rx_sreq), 1);
    check("R4 rx burst needs level above trigger and 4", int'(rx_breq), 0);
    rx_level = 4'd4;
    tick();
    check("R4 rx burst at level 4", int'(rx_breq), 1);
    for (int i = 0; i < 5; i++) begin
      rx_pop = 1;
      tick();
    end
    rx_pop = 0;
    check("R8 rx quiet after burst", int'(rx_sreq), 0);
    rx_level = 0; tx_level = 0;

    // restart mid burst with a short length
    trig_lvl = 3'd5; burst_len = 8'd10; burst_cmd = 1;
    tick();
    burst_cmd = 0;
    tx_push = 1;
    repeat (3) tick();
    tx_push = 0;
    burst_len = 8'd3; burst_cmd = 1; tx_push = 1;
    tick();
    burst_cmd = 0; tx_push = 0;
    check("R7 restart loads 3 so no burst request", int'(tx_breq), 0);
    check("R7 restart keeps single request", int'(tx_sreq), 1);

    // zero-length burst
    burst_len = 8'd0; burst_cmd = 1; rx_level = 4'd6;
    tick();
    burst_cmd = 0;
    check("R8 zero length tx", int'(tx_sreq), 0);
    check("R8 zero length rx", int'(rx_breq), 0);
    rx_level = 0;

    // interrupt flags
    int_mask = 2'b01; done_tx = 1;
    tick();
    done_tx = 0;
    check("R10 tx done sets raw", int'(int_raw), 1);
    check("R11 irq with mask", int'(irq), 1);
    int_mask = 2'b00;
    #1 check("R11 masked off", int'(irq), 0);
    done_rx = 1; int_clr = 2'b11;
    tick();
    idle_strobes();
    check("R10 set wins over clear", int'(int_raw), 2);
    int_clr = 2'b01;
    tick();
    int_clr = 2'b00;
    check("R11 clear of other bit leaves rx", int'(int_raw), 2);
    int_clr = 2'b10;
    tick();
    int_clr = 2'b00;
    check("R11 w1c clears rx", int'(int_raw), 0);

    // random phase
    for (int c = 0; c < 3000; c++) begin
      burst_en  = ($urandom_range(0, 9) != 0);
      chan_sel  = ($urandom_range(0, 9) != 0);
      burst_cmd = ($urandom_range(0, 15) == 0);
      burst_len = LEN_W'($urandom_range(0, 12));
      trig_lvl  = TRIG_W'($urandom_range(0, 7));
      tx_level  = LVL_W'($urandom_range(0, 8));
      rx_level  = LVL_W'($urandom_range(0, 8));
      tx_push   = $urandom_range(0, 2) == 0;
      rx_pop    = $urandom_range(0, 2) == 0;
      done_tx   = $urandom_range(0, 7) == 0;
      done_rx   = $urandom_range(0, 7) == 0;
      int_clr   = 2'($urandom_range(0, 3));
      int_mask  = 2'($urandom_range(0, 3));
      tick();
    end
    idle_strobes();
    tick();
    summary();
  end
endmodule